// File: doc/BRIEF.md
# Dual-Channel Digital Potentiometer Serial Register Slave

This block is the serial control front end of a two-channel, 256-step digital potentiometer. It watches an I2C-compatible two-wire bus (clock and data lines) with its own system clock. It finds START and STOP conditions, answers only its own 7-bit address, and keeps the wiper codes and the control outputs that the analog network and the pin drivers use.

A write transaction sends an instruction byte, then any number of data bytes. The instruction byte selects a channel, can request a midscale preset, and sets the shutdown flag and two general-purpose logic outputs. Each data byte loads the wiper of the selected channel. A read transaction returns the wiper of the channel that the most recent instruction selected. The block drives the shared data line only through an active-high pull-down enable.

Top module: `dpot_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits are 0,1,0,1,1 followed by `strap_a1` and then `strap_a0` (bit 0 is R/W, 1 = read). Any other address gets no acknowledge and changes no output.
- R2: An SDA fall while SCL is high (START) restarts address reception from any state, including in the middle of a transaction. An SDA rise while SCL is high (STOP) returns the block to idle and releases the line.
- R3: Bytes are shifted MSB first on rising SCL edges, and the ninth clock is the acknowledge slot. `sda_pull` is high only during slave acknowledge slots and during read data bits that are 0.
- R4: Instruction byte fields: bit 7 selects the channel, bit 6 requests midscale, bit 5 = 1 drives `shdn_n` low, bit 4 sets `gpo2`, bit 3 sets `gpo1`, and bits 2:0 are ignored. The fields take effect when the instruction's acknowledge slot begins.
- R5: In a write, the byte after the instruction byte, and every byte after it, loads the wiper of the selected channel when that byte's acknowledge slot begins.
- R6: In a read, the wiper of the selected channel is driven MSB first right after the address acknowledge. A master ACK (0) on the ninth clock starts another copy of the byte. A NACK (1) ends driving.
- R7: The channel selection persists across transactions. It is also updated by a write that ends after the instruction byte or is cut short by a repeated START.
- R8: A midscale request loads 8'h80 into the channel named in the same instruction byte, so the preset and the selection change land together.
- R9: After reset, both wipers are 8'h80, channel 0 is selected, `shdn_n` is 1, `gpo1`/`gpo2` are 0 and `sda_pull` is 0.
- R10: Wipers change only at instruction or data commits, and `sda_pull` changes only on a synchronized SCL fall, START or STOP, never during SCL high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_a0 | input | 1 | Address strap, address bit 0 |
| strap_a1 | input | 1 | Address strap, address bit 1 |
| sda_pull | output | 1 | Active-high pull-down enable for the data line |
| wiper0 | output | 8 | Wiper code of channel 0 |
| wiper1 | output | 8 | Wiper code of channel 1 |
| shdn_n | output | 1 | Shutdown, active low |
| gpo1 | output | 1 | General-purpose logic output 1 |
| gpo2 | output | 1 | General-purpose logic output 2 |

## Verification
Two operations can share one clock edge: the instruction commit that changes the channel selection, and the midscale preset that must land on the newly named channel, not the old one. The bench provokes this by sending, while channel 0 is selected, an instruction that selects channel 1 and requests midscale. The reference model applies both in a single step, so a preset that lands on channel 0, or one cycle late, shows up in the per-clock wiper comparison and in the readback that follows. The same bench also compares every cycle the data-line pull-down against the model's acknowledge and read-bit timing.

// File: rtl/dpot_pkg.sv
// Package: shared constants and types for the potentiometer bus slave.
// Assumes one byte per bus transfer and exactly two wiper channels.
package dpot_pkg;
    localparam int BYTE_W = 8;
    localparam int NUM_CH = 2;
    localparam logic [4:0] ADDR_PREFIX = 5'b01011;

    // Instruction byte bit positions
    localparam int INS_SEL = 7;
    localparam int INS_MID = 6;
    localparam int INS_SD  = 5;
    localparam int INS_O2  = 4;
    localparam int INS_O1  = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } bus_state_e;
endpackage

// File: rtl/dpot_bus_sync.sv
// Module: two-line synchronizer and bus event detector.
// Synchronizes SCL and SDA through STAGES flops, then compares each line
// with its value one cycle earlier to produce one-cycle event pulses.
// Assumes an idle bus is high on both lines and that STAGES >= 2.
module dpot_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    localparam int CHAIN_W = 2 * STAGES;

    logic [CHAIN_W-1:0] chain;
    logic               scl_s;
    logic               scl_d;
    logic               sda_d;

    // Shift both lines through the synchronizer chain (pairs of {scl, sda})
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[CHAIN_W-3:0], scl_i, sda_i};
        end
    end

    assign scl_s = chain[CHAIN_W-1];
    assign sda_s = chain[CHAIN_W-2];

    // Keep the previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/dpot_i2c_fsm.sv
// Module: byte-level protocol engine for the potentiometer slave.
// Receives address, instruction and data bytes, drives acknowledges and
// read data, and emits one-cycle commit strobes for the register file.
// Assumes event pulses from dpot_bus_sync; START and STOP outrank bit events.
module dpot_i2c_fsm
    import dpot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic [6:0]        dev_addr,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              ins_we,
    output logic              dat_we,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sda_pull
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    bus_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic              rw;
    logic              byte_done;
    logic              quiet;

    assign quiet     = ~start_p & ~stop_p;
    assign byte_done = quiet & scl_fall & (cnt == FULL);

    // Protocol state, bit counter and shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
            sh  <= '0;
            tx  <= '0;
            rw  <= 1'b0;
        end else if (stop_p) begin
            st <= ST_IDLE;
        end else if (start_p) begin
            st  <= ST_ADDR;
            cnt <= '0;
        end else begin
            case (st)
                ST_ADDR, ST_INSTR, ST_WDATA: begin
                    if (scl_rise && cnt != FULL) begin
                        sh  <= {sh[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (byte_done) begin
                        cnt <= '0;
                        if (st == ST_ADDR) begin
                            if (sh[BYTE_W-1:1] == dev_addr) begin
                                rw <= sh[0];
                                st <= ST_ADDR_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else if (st == ST_INSTR) begin
                            st <= ST_INSTR_ACK;
                        end else begin
                            st <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw) begin
                            st <= ST_RDATA;
                            tx <= rd_byte;
                        end else begin
                            st <= ST_INSTR;
                        end
                    end
                end
                ST_INSTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) st <= ST_WDATA;
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (cnt == LAST) begin
                            st  <= ST_RDATA_ACK;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                            tx  <= {tx[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise && sda_s) begin
                        st <= ST_IDLE;
                    end else if (scl_fall) begin
                        st <= ST_RDATA;
                        tx <= rd_byte;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign ins_we  = byte_done & (st == ST_INSTR);
    assign dat_we  = byte_done & (st == ST_WDATA);
    assign rx_byte = sh;

    assign sda_pull = (st == ST_ADDR_ACK) | (st == ST_INSTR_ACK) |
                      (st == ST_WDATA_ACK) | ((st == ST_RDATA) & ~tx[BYTE_W-1]);
endmodule

// File: rtl/dpot_regfile.sv
// Module: wiper and control register file.
// Applies instruction commits (select, midscale, shutdown, logic outputs)
// and data commits (wiper of the selected channel); serves readback data.
// Assumes commit strobes are one cycle wide and never coincide.
module dpot_regfile
    import dpot_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ins_we,
    input  logic                     dat_we,
    input  logic [BYTE_W-1:0]        byte_in,
    output logic [NUM_CH*BYTE_W-1:0] wipers,
    output logic                     sel,
    output logic                     shdn_n,
    output logic                     gpo1,
    output logic                     gpo2,
    output logic [BYTE_W-1:0]        rd_byte
);
    localparam logic [BYTE_W-1:0] MIDSCALE = BYTE_W'(1) << (BYTE_W - 1);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [BYTE_W-1:0] q;

        // One wiper: midscale preset from the instruction, or data load
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= MIDSCALE;
            end else if (ins_we && byte_in[INS_MID] && byte_in[INS_SEL] == 1'(ch)) begin
                q <= MIDSCALE;
            end else if (dat_we && sel == 1'(ch)) begin
                q <= byte_in;
            end
        end

        assign wipers[ch*BYTE_W +: BYTE_W] = q;
    end

    // Control fields captured from the instruction byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel    <= 1'b0;
            shdn_n <= 1'b1;
            gpo1   <= 1'b0;
            gpo2   <= 1'b0;
        end else if (ins_we) begin
            sel    <= byte_in[INS_SEL];
            shdn_n <= ~byte_in[INS_SD];
            gpo2   <= byte_in[INS_O2];
            gpo1   <= byte_in[INS_O1];
        end
    end

    assign rd_byte = wipers[int'(sel)*BYTE_W +: BYTE_W];
endmodule

// File: rtl/dpot_i2c_slave.sv
// Module: top of the dual-channel potentiometer serial slave.
// Ties the bus synchronizer, the protocol engine and the register file.
// Assumes straps are static and the bus obeys the two-wire timing rules.
module dpot_i2c_slave
    import dpot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       strap_a0,
    input  logic       strap_a1,
    output logic       sda_pull,
    output logic [7:0] wiper0,
    output logic [7:0] wiper1,
    output logic       shdn_n,
    output logic       gpo1,
    output logic       gpo2
);
    logic                     sda_s;
    logic                     scl_rise;
    logic                     scl_fall;
    logic                     start_p;
    logic                     stop_p;
    logic                     ins_we;
    logic                     dat_we;
    logic                     sel;
    logic [BYTE_W-1:0]        rx_byte;
    logic [BYTE_W-1:0]        rd_byte;
    logic [NUM_CH*BYTE_W-1:0] wipers;
    logic [6:0]               dev_addr;

    assign dev_addr = {ADDR_PREFIX, strap_a1, strap_a0};

    dpot_bus_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    dpot_i2c_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p),
        .dev_addr (dev_addr),
        .rd_byte  (rd_byte),
        .ins_we   (ins_we),
        .dat_we   (dat_we),
        .rx_byte  (rx_byte),
        .sda_pull (sda_pull)
    );

    dpot_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ins_we  (ins_we),
        .dat_we  (dat_we),
        .byte_in (rx_byte),
        .wipers  (wipers),
        .sel     (sel),
        .shdn_n  (shdn_n),
        .gpo1    (gpo1),
        .gpo2    (gpo2),
        .rd_byte (rd_byte)
    );

    assign wiper0 = wipers[BYTE_W-1:0];
    assign wiper1 = wipers[2*BYTE_W-1:BYTE_W];
endmodule

// File: rtl/dpot_i2c_slave_sva.sv
// Module: assertion checker bound to dpot_i2c_slave.
// Relates the commit strobes and bus events to the register outputs and
// to the data-line pull-down. Assumes the top's internal signal names.
module dpot_i2c_slave_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_fall,
    input logic       start_p,
    input logic       stop_p,
    input logic       ins_we,
    input logic       dat_we,
    input logic       sel,
    input logic [7:0] rx_byte,
    input logic       sda_pull,
    input logic [7:0] wiper0,
    input logic [7:0] wiper1,
    input logic       shdn_n,
    input logic       gpo1,
    input logic       gpo2
);
    assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !sda_pull);

    assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_we |=> $stable({shdn_n, gpo1, gpo2}));

    assert_data_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dat_we |=> (($past(sel) ? wiper1 : wiper0) == $past(rx_byte)));

    assert_midscale_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_we && rx_byte[6]) |=> (($past(rx_byte[7]) ? wiper1 : wiper0) == 8'h80));

    assert_wiper_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_we && !dat_we) |=> ($stable(wiper0) && $stable(wiper1)));

    assert_pull_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_fall || start_p || stop_p) |=> $stable(sda_pull));
endmodule

bind dpot_i2c_slave dpot_i2c_slave_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .ins_we   (ins_we),
    .dat_we   (dat_we),
    .sel      (sel),
    .rx_byte  (rx_byte),
    .sda_pull (sda_pull),
    .wiper0   (wiper0),
    .wiper1   (wiper1),
    .shdn_n   (shdn_n),
    .gpo1     (gpo1),
    .gpo2     (gpo2)
);

// File: tb/tb_dpot_i2c_slave.sv
`timescale 1ns/1ps
// Bench: drives the two-wire bus as a master, keeps a behavioural model of
// the expected outputs and compares them with the design on every clock.
module tb_dpot_i2c_slave;
    localparam int H = 8;
    localparam int LAT = 3;
    localparam logic [6:0] MY_ADDR = 7'b0101110;
    localparam logic [6:0] BAD_ADDR = 7'b0101101;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;
    logic [7:0] wiper0, wiper1;
    logic shdn_n, gpo1, gpo2;

    assign sda_line = sda_m & ~sda_pull;

    dpot_i2c_slave dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .strap_a0 (1'b0),
        .strap_a1 (1'b1),
        .sda_pull (sda_pull),
        .wiper0   (wiper0),
        .wiper1   (wiper1),
        .shdn_n   (shdn_n),
        .gpo1     (gpo1),
        .gpo2     (gpo2)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    // Model: f_* is the state after the latest bus event, e_* what the ports show
    logic [7:0] f_w [2];
    logic [7:0] e_w [2];
    logic f_sel = 0, f_sd = 0, f_o1 = 0, f_o2 = 0, f_pull = 0;
    logic e_sd = 0, e_o1 = 0, e_o2 = 0, e_pull = 0;
    int pend = 0;

    initial begin
        f_w[0] = 8'h80; f_w[1] = 8'h80;
        e_w[0] = 8'h80; e_w[1] = 8'h80;
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Model latency: two synchronizer flops plus the state register
    always @(posedge clk) begin
        if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) begin
                e_w[0] = f_w[0]; e_w[1] = f_w[1];
                e_sd = f_sd; e_o1 = f_o1; e_o2 = f_o2; e_pull = f_pull;
            end
        end
    end

    // Per-clock comparison of all outputs against the model
    always @(negedge clk) begin
        if (live && !done) begin
            chk("R5 wiper0", wiper0, e_w[0]);
            chk("R5 wiper1", wiper1, e_w[1]);
            chk("R4 shdn_n", {7'd0, shdn_n}, {7'd0, ~e_sd});
            chk("R4 gpo1", {7'd0, gpo1}, {7'd0, e_o1});
            chk("R4 gpo2", {7'd0, gpo2}, {7'd0, e_o2});
            chk("R3 R10 sda_pull", {7'd0, sda_pull}, {7'd0, e_pull});
        end
    end

    task automatic set_bus(input logic c, input logic d);
        @(negedge clk);
        scl_m = c;
        sda_m = d;
    endtask

    task automatic hold();
        repeat (H - 1) @(negedge clk);
    endtask

    task automatic bit_slot(input logic d, input logic nxt_pull, output logic seen);
        set_bus(1'b0, d);
        hold();
        set_bus(1'b1, d);
        hold();
        seen = sda_line;
        set_bus(1'b0, d);
        f_pull = nxt_pull;
        pend = LAT;
        hold();
    endtask

    task automatic apply_ins(input logic [7:0] b);
        f_sel = b[7];
        f_sd  = b[5];
        f_o2  = b[4];
        f_o1  = b[3];
        if (b[6]) f_w[b[7]] = 8'h80;
    endtask

    // kind: 0 address, 1 instruction, 2 data
    task automatic wr_byte(input logic [7:0] b, input int kind, input logic acked,
                           input logic then_read, input string tag);
        logic s;
        for (int i = 7; i >= 1; i--) bit_slot(b[i], 1'b0, s);
        if (acked && kind == 1) apply_ins(b);
        if (acked && kind == 2) f_w[f_sel] = b;
        bit_slot(b[0], acked, s);
        bit_slot(1'b1, (then_read && acked) ? ~f_w[f_sel][7] : 1'b0, s);
        chk(tag, {7'd0, s}, {7'd0, ~acked});
    endtask

    task automatic rd_byte(input logic mack, input logic [7:0] expv, input string tag);
        logic s;
        logic [7:0] v;
        logic [7:0] got;
        v = f_w[f_sel];
        for (int i = 7; i >= 0; i--) begin
            bit_slot(1'b1, (i > 0) ? ~v[(i > 0) ? i - 1 : 0] : 1'b0, s);
            got[i] = s;
        end
        chk(tag, got, expv);
        bit_slot(~mack, mack ? ~v[7] : 1'b0, s);
    endtask

    task automatic do_start();
        if (scl_m == 1'b0) begin
            set_bus(1'b0, 1'b1); hold();
            set_bus(1'b1, 1'b1); hold();
        end
        set_bus(1'b1, 1'b0); hold();
        set_bus(1'b0, 1'b0); hold();
    endtask

    task automatic do_stop();
        set_bus(1'b0, 1'b0); hold();
        set_bus(1'b1, 1'b0); hold();
        set_bus(1'b1, 1'b1); hold();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9 wiper0", wiper0, 8'h80);
        chk("R9 wiper1", wiper1, 8'h80);
        chk("R9 shdn_n", {7'd0, shdn_n}, 8'd1);
        chk("R9 gpo", {6'd0, gpo2, gpo1}, 8'd0);
        chk("R9 sda_pull", {7'd0, sda_pull}, 8'd0);
        live = 1'b1;

        // R1: foreign address is ignored
        do_start();
        wr_byte({BAD_ADDR, 1'b0}, 0, 1'b0, 1'b0, "R1 no ack foreign address");
        do_stop();

        // R1 R5: own address, select channel 1 with gpo2, two data bytes
        do_start();
        wr_byte({MY_ADDR, 1'b0}, 0, 1'b1, 1'b0, "R1 ack own address");
        wr_byte(8'h90, 1, 1'b1, 1'b0, "R4 ack instruction");
        wr_byte(8'h3C, 2, 1'b1, 1'b0, "R5 ack first data");
        wr_byte(8'hA5, 2, 1'b1, 1'b0, "R5 ack repeated data");
        do_stop();
        chk("R5 repeated data lands on ch1", wiper1, 8'hA5);
        chk("R5 ch0 untouched", wiper0, 8'h80);

        // R6: read with master ACK then NACK
        do_start();
        wr_byte({MY_ADDR, 1'b1}, 0, 1'b1, 1'b1, "R6 ack read address");
        rd_byte(1'b1, 8'hA5, "R6 first read byte");
        rd_byte(1'b0, 8'hA5, "R6 second read byte");
        do_stop();

        // R4 R2: ignored low bits, shutdown and gpo1, repeated START into read
        do_start();
        wr_byte({MY_ADDR, 1'b0}, 0, 1'b1, 1'b0, "R1 ack own address");
        wr_byte(8'h2F, 1, 1'b1, 1'b0, "R4 ack instruction");
        wr_byte(8'h11, 2, 1'b1, 1'b0, "R5 ack data");
        do_start();
        wr_byte({MY_ADDR, 1'b1}, 0, 1'b1, 1'b1, "R2 ack after repeated start");
        rd_byte(1'b0, 8'h11, "R2 read after repeated start");
        do_stop();
        chk("R4 shutdown asserted", {7'd0, shdn_n}, 8'd0);
        chk("R4 gpo1 set gpo2 clear", {6'd0, gpo2, gpo1}, 8'd1);

        // R8 R7: select channel 1 with midscale in one byte, stop after instruction
        do_start();
        wr_byte({MY_ADDR, 1'b0}, 0, 1'b1, 1'b0, "R1 ack own address");
        wr_byte(8'hC0, 1, 1'b1, 1'b0, "R8 ack instruction");
        do_stop();
        chk("R8 midscale on newly selected ch1", wiper1, 8'h80);
        chk("R8 ch0 kept", wiper0, 8'h11);
        do_start();
        wr_byte({MY_ADDR, 1'b1}, 0, 1'b1, 1'b1, "R7 ack read address");
        rd_byte(1'b0, 8'h80, "R7 read follows instruction-only write");
        do_stop();

        // R7: instruction cut by repeated START selects channel 0
        do_start();
        wr_byte({MY_ADDR, 1'b0}, 0, 1'b1, 1'b0, "R1 ack own address");
        wr_byte(8'h00, 1, 1'b1, 1'b0, "R7 ack instruction");
        do_start();
        wr_byte({MY_ADDR, 1'b1}, 0, 1'b1, 1'b1, "R7 ack read address");
        rd_byte(1'b0, 8'h11, "R7 read after cut write");
        do_stop();

        // R3 R6: all-zero byte keeps the line pulled for every read bit
        do_start();
        wr_byte({MY_ADDR, 1'b0}, 0, 1'b1, 1'b0, "R1 ack own address");
        wr_byte(8'h00, 1, 1'b1, 1'b0, "R4 ack instruction");
        wr_byte(8'h00, 2, 1'b1, 1'b0, "R5 ack data");
        do_stop();
        do_start();
        wr_byte({MY_ADDR, 1'b1}, 0, 1'b1, 1'b1, "R6 ack read address");
        rd_byte(1'b0, 8'h00, "R3 read of zero byte");
        do_stop();

        repeat (10) @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run is counted as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule